// File: doc/BRIEF.md
# Misaligned Access Two-Bank Splitter

The block takes one load or store request, made of a byte address, a byte count from 1 to 16 and, for stores, right-aligned data. It divides the request across two outgoing bank ports. Memory is viewed as 16-byte lines. Address bit 4 splits the lines into an even bank and an odd bank. Each bank port receives a line address, a 16-bit per-byte enable mask and, for a store, the data already moved into its byte lanes. A request that crosses a line boundary always reaches both banks in the same cycle, because two adjacent lines never fall in the same bank.

Bank requests are issued combinationally in the cycle the request is accepted. Stores need nothing more from the block. For a load, the block records which banks were asked. It then waits until every asked bank has returned its line, rebuilds the bytes in request order, right-aligns them and presents the result for exactly one cycle. Each bank's return may arrive after any delay, and the two returns may arrive in the same cycle. Until the load completes, the block reports busy and ignores new requests.

Top module: `msplit_top`

## Requirements
- R1: A request with address bit 4 equal to 0 starts on bank 0, and one with bit 4 equal to 1 starts on bank 1. The starting bank's line address is address bits 47:4. The other bank's line address is that value plus one. The line address bit 0 that a bank is given always equals its bank number.
- R2: The 32-bit span mask is ((1<<len)-1) shifted left by address bits 3:0. Bits 15:0 of the span mask are the starting bank's byte enables, and bits 31:16 are the other bank's byte enables. A bank whose enables are all zero gets no request, and the enable bits of both banks together count exactly len.
- R3: For a store, data byte i goes to span lane (address bits 3:0)+i. Lanes 0 to 15 of the span go to the starting bank and lanes 16 to 31 go to the other bank, with byte lane k on data bits 8k+7:8k. Lanes that are not enabled carry zero. Each requesting bank sees its write-enable bit set.
- R4: A request with a length of 0, or of more than 16, issues no bank request and does not make the block busy.
- R5: A load raises busy_o from the edge that accepts it. ld_vld_o is high for one cycle only. That cycle comes right after the clock edge that samples the last outstanding bank return. busy_o falls after that cycle.
- R6: The load result holds the bytes at address+0 up to address+len-1 in byte lanes 0 to len-1. All higher lanes are zero.
- R7: While busy_o is high, any new request is ignored: no bank port is asserted, and the pending load's result is unaffected.
- R8: A return from a bank that has no outstanding load is ignored. It neither completes the load nor changes the result.
- R9: After reset, busy_o, ld_vld_o and both bank valids are low.
- R10: When both banks of a line-crossing load return in the same cycle, the load completes in the next cycle with the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld_i | input | 1 | Request present this cycle |
| req_is_st_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 48 | Byte address |
| req_len_i | input | 5 | Byte count, 1 to 16 |
| req_wdata_i | input | 128 | Store data, byte 0 in bits 7:0 |
| busy_o | output | 1 | Load in progress; requests ignored |
| bank_vld_o | output | 2 | Per-bank request valid (bit b = bank b) |
| bank_we_o | output | 2 | Per-bank write enable |
| bank_line_o | output | 88 | Per-bank line address, bank b in bits 44b+43:44b |
| bank_be_o | output | 32 | Per-bank byte enables, bank b in bits 16b+15:16b |
| bank_wdata_o | output | 256 | Per-bank lane-aligned store data, bank b in bits 128b+127:128b |
| bank_rvld_i | input | 2 | Per-bank load return valid |
| bank_rdata_i | input | 256 | Per-bank returned line, bank b in bits 128b+127:128b |
| ld_vld_o | output | 1 | Load result valid (one cycle) |
| ld_data_o | output | 128 | Right-aligned load result |

## Verification
The two bank returns of a line-crossing load can land in the same cycle. Completion then depends on both captures and on the check that all returns are in, all at one edge. The bench covers this case with a load whose two modelled bank delays are equal, and it also runs a staggered case. In each case it judges the exact cycle of the ld_vld_o pulse and the rebuilt bytes against values it computes from the address alone. A second collision covered is a new request, or a stray return from a bank with no outstanding load, arriving while a load is still pending. The bench checks that no bank port fires and that the later result is unchanged.

// File: rtl/msplit_pkg.sv
// Package: shared constants and types for the two-bank splitter.
// Assumes exactly two line banks selected by the lowest line-address bit.
package msplit_pkg;
    localparam int NBANK = 2;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_WAIT = 2'd1,
        GS_DONE = 2'd2
    } gather_state_e;
endpackage

// File: rtl/msplit_lane_shift.sv
// Module: builds the two-line byte span mask and the lane-shifted store data.
// Assumes len_i is only meaningful when len_ok_o is high; disabled lanes are zeroed.
module msplit_lane_shift #(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LEN_W  = OFF_W + 1,
    localparam int DATA_W = 8 * LINE_BYTES,
    localparam int SPAN   = 2 * LINE_BYTES
) (
    input  logic [OFF_W-1:0]    off_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                len_ok_o,
    output logic [SPAN-1:0]     mask_o,
    output logic [2*DATA_W-1:0] wdata_o
);
    logic [SPAN-1:0]     base;
    logic [2*DATA_W-1:0] shifted;

    // Length check, run-of-ones mask and byte shift of store data.
    always_comb begin
        len_ok_o = (len_i != '0) && (len_i <= LEN_W'(LINE_BYTES));
        base     = (SPAN'(1) << len_i) - SPAN'(1);
        mask_o   = base << off_i;
        shifted  = {{DATA_W{1'b0}}, wdata_i} << {off_i, 3'b000};
    end

    // Zero every byte lane that the mask does not enable.
    for (genvar g = 0; g < SPAN; g++) begin : g_lane
        assign wdata_o[g*8 +: 8] = shifted[g*8 +: 8] & {8{mask_o[g]}};
    end
endmodule

// File: rtl/msplit_bank_route.sv
// Module: selects the span half, line address and enables for one bank.
// Assumes the starting bank takes the low half and the other bank the next line.
module msplit_bank_route #(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 16,
    parameter int BANK       = 0,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int DATA_W = 8 * LINE_BYTES,
    localparam int SPAN   = 2 * LINE_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic                we_i,
    input  logic                start_bank_i,
    input  logic [LINE_W-1:0]   line_i,
    input  logic [SPAN-1:0]     mask_i,
    input  logic [2*DATA_W-1:0] wdata_i,
    output logic                vld_o,
    output logic                we_o,
    output logic [LINE_W-1:0]   line_o,
    output logic [LINE_BYTES-1:0] be_o,
    output logic [DATA_W-1:0]   wdata_o
);
    logic use_lo;

    // Pick the low or high half of the span for this bank.
    always_comb begin
        use_lo  = (start_bank_i == 1'(BANK));
        be_o    = use_lo ? mask_i[LINE_BYTES-1:0] : mask_i[SPAN-1:LINE_BYTES];
        wdata_o = use_lo ? wdata_i[DATA_W-1:0]   : wdata_i[2*DATA_W-1:DATA_W];
        line_o  = use_lo ? line_i : line_i + LINE_W'(1);
        vld_o   = accept_i && (be_o != '0);
        we_o    = vld_o && we_i;
    end

    AST_BANK_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (line_o[0] == 1'(BANK))); // R1
endmodule

// File: rtl/msplit_load_gather.sv
// Module: tracks outstanding bank returns of one load and rebuilds the result.
// Assumes returns arrive at least one cycle after the issuing cycle.
module msplit_load_gather
    import msplit_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LEN_W  = OFF_W + 1,
    localparam int DATA_W = 8 * LINE_BYTES,
    localparam int SPAN   = 2 * LINE_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NBANK-1:0]        pend_i,
    input  logic                    start_bank_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic [LEN_W-1:0]        len_i,
    input  logic [NBANK-1:0]        rvld_i,
    input  logic [NBANK*DATA_W-1:0] rdata_i,
    output logic                    busy_o,
    output logic                    ld_vld_o,
    output logic [DATA_W-1:0]       ld_data_o
);
    gather_state_e                 state_q;
    logic [NBANK-1:0]              pend_q;
    logic [NBANK-1:0][DATA_W-1:0]  data_q;
    logic                          sb_q;
    logic [OFF_W-1:0]              off_q;
    logic [LEN_W-1:0]              len_q;
    logic [NBANK-1:0]              take;
    logic [2*DATA_W-1:0]           joined;
    logic [SPAN-1:0]               keep;

    assign take = pend_q & rvld_i;

    // Load tracking state: capture returns and advance to completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            pend_q  <= '0;
            sb_q    <= 1'b0;
            off_q   <= '0;
            len_q   <= '0;
        end else begin
            case (state_q)
                GS_IDLE: if (start_i) begin
                    state_q <= GS_WAIT;
                    pend_q  <= pend_i;
                    sb_q    <= start_bank_i;
                    off_q   <= off_i;
                    len_q   <= len_i;
                end
                GS_WAIT: begin
                    pend_q <= pend_q & ~rvld_i;
                    if ((pend_q & ~rvld_i) == '0) state_q <= GS_DONE;
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    // Returned line storage, written only for outstanding banks.
    for (genvar b = 0; b < NBANK; b++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n) data_q[b] <= '0;
            else if (state_q == GS_WAIT && take[b]) data_q[b] <= rdata_i[b*DATA_W +: DATA_W];
        end
    end

    // Rebuild request order, right-align and clear bytes past the length.
    always_comb begin
        joined = {data_q[~sb_q], data_q[sb_q]} >> {off_q, 3'b000};
        keep   = (SPAN'(1) << len_q) - SPAN'(1);
    end

    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_out
        assign ld_data_o[g*8 +: 8] = joined[g*8 +: 8] & {8{keep[g]}};
    end

    assign busy_o   = (state_q != GS_IDLE);
    assign ld_vld_o = (state_q == GS_DONE);

    AST_LD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld_o |=> !ld_vld_o); // R5
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R7
    AST_WAIT_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_WAIT) |-> (pend_q != '0)); // R8
endmodule

// File: rtl/msplit_top.sv
// Module: splits one load/store request across an even and an odd line bank.
// Assumes at most one load outstanding; requests while busy are dropped.
module msplit_top
    import msplit_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LEN_W  = OFF_W + 1,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int DATA_W = 8 * LINE_BYTES,
    localparam int SPAN   = 2 * LINE_BYTES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_vld_i,
    input  logic                      req_is_st_i,
    input  logic [ADDR_W-1:0]         req_addr_i,
    input  logic [LEN_W-1:0]          req_len_i,
    input  logic [DATA_W-1:0]         req_wdata_i,
    output logic                      busy_o,
    output logic [NBANK-1:0]          bank_vld_o,
    output logic [NBANK-1:0]          bank_we_o,
    output logic [NBANK*LINE_W-1:0]   bank_line_o,
    output logic [NBANK*LINE_BYTES-1:0] bank_be_o,
    output logic [NBANK*DATA_W-1:0]   bank_wdata_o,
    input  logic [NBANK-1:0]          bank_rvld_i,
    input  logic [NBANK*DATA_W-1:0]   bank_rdata_i,
    output logic                      ld_vld_o,
    output logic [DATA_W-1:0]         ld_data_o
);
    logic                len_ok;
    logic [SPAN-1:0]     span_mask;
    logic [2*DATA_W-1:0] span_wdata;
    logic                accept;
    logic                start_bank;

    assign start_bank = req_addr_i[OFF_W];
    assign accept     = req_vld_i && len_ok && !busy_o;

    msplit_lane_shift #(.LINE_BYTES(LINE_BYTES)) shift_i (
        .off_i    (req_addr_i[OFF_W-1:0]),
        .len_i    (req_len_i),
        .wdata_i  (req_wdata_i),
        .len_ok_o (len_ok),
        .mask_o   (span_mask),
        .wdata_o  (span_wdata)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        msplit_bank_route #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BANK(b)) route_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .accept_i     (accept),
            .we_i         (req_is_st_i),
            .start_bank_i (start_bank),
            .line_i       (req_addr_i[ADDR_W-1:OFF_W]),
            .mask_i       (span_mask),
            .wdata_i      (span_wdata),
            .vld_o        (bank_vld_o[b]),
            .we_o         (bank_we_o[b]),
            .line_o       (bank_line_o[b*LINE_W +: LINE_W]),
            .be_o         (bank_be_o[b*LINE_BYTES +: LINE_BYTES]),
            .wdata_o      (bank_wdata_o[b*DATA_W +: DATA_W])
        );
    end

    msplit_load_gather #(.LINE_BYTES(LINE_BYTES)) gather_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept && !req_is_st_i),
        .pend_i       (bank_vld_o),
        .start_bank_i (start_bank),
        .off_i        (req_addr_i[OFF_W-1:0]),
        .len_i        (req_len_i),
        .rvld_i       (bank_rvld_i),
        .rdata_i      (bank_rdata_i),
        .busy_o       (busy_o),
        .ld_vld_o     (ld_vld_o),
        .ld_data_o    (ld_data_o)
    );

    AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (bank_vld_o == '0)); // R7
    AST_MASK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($countones(bank_be_o) == int'(req_len_i))); // R2
    AST_BAD_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && !len_ok) |-> (bank_vld_o == '0)); // R4
    AST_START_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> bank_vld_o[start_bank]); // R1
endmodule

// File: tb/msplit_top_tb_top.sv
module msplit_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_vld = 1'b0, req_is_st = 1'b0;
    logic [47:0] req_addr = '0;
    logic [4:0] req_len = '0;
    logic [127:0] req_wdata = '0;
    logic busy, ld_vld;
    logic [1:0] bank_vld, bank_we;
    logic [87:0] bank_line;
    logic [31:0] bank_be;
    logic [255:0] bank_wdata;
    logic [1:0] bank_rvld = '0;
    logic [255:0] bank_rdata = '0;
    logic [127:0] ld_data;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [127:0] exp_data_q[$];
    int exp_cyc_q[$];
    logic [43:0] cap_line [2];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    msplit_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld), .req_is_st_i(req_is_st),
        .req_addr_i(req_addr), .req_len_i(req_len), .req_wdata_i(req_wdata),
        .busy_o(busy), .bank_vld_o(bank_vld), .bank_we_o(bank_we),
        .bank_line_o(bank_line), .bank_be_o(bank_be), .bank_wdata_o(bank_wdata),
        .bank_rvld_i(bank_rvld), .bank_rdata_i(bank_rdata),
        .ld_vld_o(ld_vld), .ld_data_o(ld_data)
    );

    function automatic logic [7:0] mem_byte(input logic [47:0] a);
        logic [47:0] t;
        t = a * 48'd29 + 48'd7;
        return t[7:0];
    endfunction

    function automatic logic [127:0] line_data(input logic [43:0] l);
        logic [127:0] d;
        for (int j = 0; j < 16; j++) d[j*8 +: 8] = mem_byte({l, 4'h0} + 48'(j));
        return d;
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Checks bank outputs for the request currently on the inputs (R1 R2 R3).
    task automatic check_issue(input logic [47:0] a, input int len, input bit st, input logic [127:0] wd);
        logic [1:0] ev;
        logic [31:0] ebe;
        logic [255:0] ewd;
        logic [87:0] eline;
        int sb, off;
        sb = a[4]; off = a[3:0];
        ev = '0; ebe = '0; ewd = '0;
        for (int i = 0; i < len; i++) begin
            int pos, bk;
            pos = off + i;
            bk = (pos < 16) ? sb : 1 - sb;
            ev[bk] = 1'b1;
            ebe[bk*16 + pos%16] = 1'b1;
            if (st) ewd[bk*128 + (pos%16)*8 +: 8] = wd[i*8 +: 8];
        end
        eline = '0;
        eline[sb*44 +: 44] = a[47:4];
        eline[(1-sb)*44 +: 44] = a[47:4] + 44'd1;
        chk("R1 bank_vld", 256'(bank_vld), 256'(ev));
        for (int b = 0; b < 2; b++)
            if (ev[b]) chk("R1 bank_line", 256'(bank_line[b*44 +: 44]), 256'(eline[b*44 +: 44]));
        chk("R2 bank_be", 256'(bank_be), 256'(ebe));
        chk("R3 bank_we", 256'(bank_we), st ? 256'(ev) : 256'(0));
        if (st) chk("R3 bank_wdata", bank_wdata, ewd);
        for (int b = 0; b < 2; b++) cap_line[b] = bank_line[b*44 +: 44];
    endtask

    task automatic do_store(input logic [47:0] a, input int len, input logic [127:0] wd);
        @(negedge clk);
        req_vld = 1; req_is_st = 1; req_addr = a; req_len = 5'(len); req_wdata = wd;
        #1 check_issue(a, len, 1'b1, wd);
        @(negedge clk);
        req_vld = 0;
        #1 chk("R5 busy after store", 256'(busy), 256'(0));
    endtask

    task automatic do_reject(input logic [47:0] a, input int len);
        @(negedge clk);
        req_vld = 1; req_is_st = 0; req_addr = a; req_len = 5'(len);
        #1 chk("R4 bad length no bank", 256'(bank_vld), 256'(0));
        @(negedge clk);
        req_vld = 0;
        #1 chk("R4 bad length not busy", 256'(busy), 256'(0));
    endtask

    // Load with per-bank return delays d0/d1 (cycles after the issue cycle).
    task automatic do_load(input logic [47:0] a, input int len, input int d0, input int d1,
                           input bit inj_busy, input bit inj_stray);
        logic [127:0] exp;
        logic [1:0] act;
        int last;
        for (int i = 0; i < 16; i++) exp[i*8 +: 8] = (i < len) ? mem_byte(a + 48'(i)) : 8'h00;
        exp_data_q.push_back(exp);
        @(negedge clk);
        req_vld = 1; req_is_st = 0; req_addr = a; req_len = 5'(len);
        #1 check_issue(a, len, 1'b0, '0);
        act = bank_vld;
        last = 0;
        if (act[0] && d0 > last) last = d0;
        if (act[1] && d1 > last) last = d1;
        @(negedge clk);
        req_vld = 0;
        #1 chk("R5 busy after load accept", 256'(busy), 256'(1));
        for (int t = 1; t <= 8; t++) begin
            @(negedge clk);
            bank_rvld = '0;
            for (int b = 0; b < 2; b++) begin
                int d;
                d = (b == 0) ? d0 : d1;
                if (act[b] && d == t) begin
                    bank_rvld[b] = 1'b1;
                    bank_rdata[b*128 +: 128] = line_data(cap_line[b]);
                end
            end
            if (inj_stray && t == 1) begin
                for (int b = 0; b < 2; b++)
                    if (!act[b]) begin
                        bank_rvld[b] = 1'b1;
                        bank_rdata[b*128 +: 128] = {16{8'hA5}};
                    end
            end
            if (t == last) exp_cyc_q.push_back(cyc + 1);
            if (inj_busy && t == 1) begin
                req_vld = 1; req_is_st = 1; req_addr = a ^ 48'h40; req_len = 5'd4;
                req_wdata = 128'h1234_5678;
                #1 chk("R7 request while busy ignored", 256'(bank_vld), 256'(0));
            end
            if (inj_stray && t == 2) chk("R8 stray return no completion", 256'(ld_vld), 256'(0));
            if (t == last + 1) chk("R5 busy until result", 256'(busy), 256'(1));
        end
        @(negedge clk);
        bank_rvld = '0; req_vld = 0;
        #1 chk("R5 busy cleared", 256'(busy), 256'(0));
    endtask

    // Monitor: pops expected results and compares the data and the cycle.
    always @(negedge clk) begin
        #2;
        if (rst_n && ld_vld) begin
            if (exp_data_q.size() == 0) begin
                chk("R5 unexpected ld_vld", 256'(1), 256'(0));
            end else begin
                logic [127:0] e;
                e = exp_data_q.pop_front();
                chk("R6 load data", 256'(ld_data), 256'(e));
                if (exp_cyc_q.size() != 0) chk("R5 ld_vld cycle", 256'(cyc), 256'(exp_cyc_q.pop_front()));
                else chk("R5 ld_vld cycle known", 256'(0), 256'(1));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset busy", 256'(busy), 256'(0));
        chk("R9 reset ld_vld", 256'(ld_vld), 256'(0));
        chk("R9 reset bank_vld", 256'(bank_vld), 256'(0));
        rst_n = 1;
        do_store(48'h0000_0000_1000, 8, 128'h8877_6655_4433_2211);
        do_store(48'h0000_0000_101C, 8, 128'hF0E0_D0C0_B0A0_9080);
        do_store(48'h0000_0000_201F, 16, 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100);
        do_store(48'hFFFF_FFFF_FFF5, 3, 128'h00CC_BBAA);
        do_reject(48'h0000_0000_3000, 0);
        do_reject(48'h0000_0000_3000, 17);
        do_load(48'h0000_0000_4000, 8, 2, 0, 0, 0);
        do_load(48'h0000_0000_501A, 12, 1, 1, 0, 0);   // R10 same-cycle returns
        do_load(48'h0000_0000_6009, 16, 3, 1, 0, 0);
        do_load(48'h0000_0000_7012, 5, 0, 2, 1, 0);    // R7 injected request
        do_load(48'h0000_0000_8003, 4, 3, 0, 0, 1);    // R8 stray return
        do_load(48'h0000_0000_901F, 1, 0, 2, 0, 0);
        repeat (4) @(negedge clk);
        chk("R6 all loads returned", 256'(exp_data_q.size()), 256'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule